// File: doc/BRIEF.md
# Pipelined Carry-Save Population Counter

The block returns how many bits are set in an input word of `WIDTH` bits (default 32, allowed from 2 up to 64). It does not chain adders of growing width. The input bits are treated as a column of weight one. Each compression stage takes every weight column and reduces it with 3:2 full adders. A full adder keeps its sum bit in the same column and sends its carry bit one column up. When the stage ends with two bits left over in a column, a half adder takes them. A single leftover bit moves on unchanged. Stages repeat until every column holds one bit. Those bits, read from the lowest weight upwards, form the binary count. No final carry-propagate adder is used.

The tree can be pipelined. The parameter `STAGES_PER_REG` places a register after every K-th compression stage, and a value of 0 makes the block purely combinational. A valid flag passes through the same registers as the data. A second output reduces the count to a small class: exactly zero, one, two, three, or more than three. The block suits a datapath that needs a popcount at a chosen clock rate, and the class output serves logic that only has to tell apart a few small counts.

Top module: `popc_csa_tree`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of set bits in the matching input word. `out_count` is $clog2(WIDTH+1) bits wide.
- R2: Within each stage, every weight column is cut into groups of three bits, and each group feeds a full adder. The sum stays in the column and the carry goes to the next higher weight. Two leftover bits go into a half adder, and one leftover bit passes unchanged. Each stage preserves the weighted total of all bits it holds.
- R3: An all-zeros word gives a count of 0. An all-ones word gives a count of exactly WIDTH.
- R4: Compression stops when every weight column holds exactly one bit. For WIDTH = 32 this takes 9 stages.
- R5: With `STAGES_PER_REG` = K > 0, a register follows every K-th stage, and the latency is floor(stages / K) clock cycles. The defaults (WIDTH = 32, K = 2) give 4 cycles. With K = 0 the count appears combinationally in the same cycle.
- R6: `out_valid` is `in_valid` delayed by the same number of registers as the data, so it marks exactly the cycles that carry a real count.
- R7: A synchronous active-high `rst` clears every valid flag in the pipeline. `out_valid` stays low after `rst` is released until a new valid word has passed through. Data registers are not reset.
- R8: `out_class` is 3 bits wide and lines up with `out_count`. Values 0, 1, 2 and 3 mean exactly that count, and value 4 means more than three. It always equals min(count, 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Marks `in_data` as a word to count |
| in_data | input | WIDTH | Word whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` and `out_class` as valid |
| out_count | output | $clog2(WIDTH+1) | Number of set bits |
| out_class | output | 3 | Saturated class: 0..3 exact, 4 = more than three |

## Verification
Each column stores its bits in a fixed order: sums first, then the leftover, then the carries arriving from below. If a bit is dropped, or sent to the wrong column, the weighted total changes at that stage. The count at the ports is then wrong for every word that sets the affected bit position, as soon as that word reaches the output. That is after the register latency, or in the same cycle when K = 0. A misplaced register or valid flag shows up as `out_valid` arriving a cycle early or late relative to the word. A valid flag that survives reset shows up as `out_valid` pulsing in the first cycles after `rst` is released.

// File: rtl/popc_pkg.sv
package popc_pkg;

    localparam int MAX_WIDTH = 64;
    localparam int MAX_COLS  = 7;

    localparam logic [2:0] CLASS_MANY = 3'd4;

    typedef struct packed {
        logic carry;
        logic sum;
    } add_out_t;

    function automatic add_out_t full_add(input logic a, input logic b, input logic c);
        add_out_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

    function automatic add_out_t half_add(input logic a, input logic b);
        add_out_t r;
        r.sum   = a ^ b;
        r.carry = a & b;
        return r;
    endfunction

    // Bits left in the same column after one stage (sums plus leftover).
    function automatic int kept_count(input int h);
        return (h / 3) + (((h % 3) != 0) ? 1 : 0);
    endfunction

    // Carries a column sends upward in one stage.
    function automatic int carry_count(input int h);
        return (h / 3) + (((h % 3) == 2) ? 1 : 0);
    endfunction

    // Number of bits held by column 'col' after 'stage' stages.
    function automatic int col_height(input int width, input int stage, input int col);
        int h  [MAX_COLS+1];
        int nh [MAX_COLS+1];
        for (int c = 0; c <= MAX_COLS; c++) h[c] = 0;
        h[0] = width;
        for (int s = 0; s < stage; s++) begin
            for (int c = 0; c <= MAX_COLS; c++) nh[c] = 0;
            for (int c = 0; c <= MAX_COLS; c++) begin
                nh[c] = nh[c] + kept_count(h[c]);
                if (c < MAX_COLS) nh[c+1] = nh[c+1] + carry_count(h[c]);
            end
            for (int c = 0; c <= MAX_COLS; c++) h[c] = nh[c];
        end
        return h[col];
    endfunction

    // Stages until every column below ncol holds at most one bit.
    function automatic int tree_depth(input int width, input int ncol);
        int  d;
        bit  done;
        d = 0;
        while (d < 64) begin
            done = 1'b1;
            for (int c = 0; c < ncol; c++)
                if (col_height(width, d, c) > 1) done = 1'b0;
            if (done) return d;
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/popc_stage.sv
module popc_stage
    import popc_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NCOL  = 6,
    parameter int STAGE = 0
) (
    input  logic [NCOL-1:0][WIDTH-1:0] bits_i,
    output logic [NCOL-1:0][WIDTH-1:0] bits_o
);

    // Sums and leftover of one column, packed from position 0.
    function automatic logic [WIDTH-1:0] keep_bits(input logic [WIDTH-1:0] v, input int h);
        logic [WIDTH-1:0] r;
        add_out_t         f;
        int               nfa;
        r   = '0;
        nfa = h / 3;
        for (int g = 0; g < WIDTH; g++) begin
            if (g < nfa) begin
                f    = full_add(v[3*g], v[3*g+1], v[3*g+2]);
                r[g] = f.sum;
            end
        end
        if ((h % 3) == 1) begin
            r[nfa] = v[3*nfa];
        end else if ((h % 3) == 2) begin
            f      = half_add(v[3*nfa], v[3*nfa+1]);
            r[nfa] = f.sum;
        end
        return r;
    endfunction

    // Carries of one column, packed from position 0.
    function automatic logic [WIDTH-1:0] carry_bits(input logic [WIDTH-1:0] v, input int h);
        logic [WIDTH-1:0] r;
        add_out_t         f;
        int               nfa;
        r   = '0;
        nfa = h / 3;
        for (int g = 0; g < WIDTH; g++) begin
            if (g < nfa) begin
                f    = full_add(v[3*g], v[3*g+1], v[3*g+2]);
                r[g] = f.carry;
            end
        end
        if ((h % 3) == 2) begin
            f      = half_add(v[3*nfa], v[3*nfa+1]);
            r[nfa] = f.carry;
        end
        return r;
    endfunction

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int HEIGHT = col_height(WIDTH, STAGE, c);
        localparam int KEPT   = kept_count(HEIGHT);

        logic [WIDTH-1:0] kept_w;
        assign kept_w = keep_bits(bits_i[c], HEIGHT);

        if (c == 0) begin : g_base
            assign bits_o[c] = kept_w;
        end else begin : g_upper
            localparam int HEIGHT_BELOW = col_height(WIDTH, STAGE, c - 1);
            logic [WIDTH-1:0] carry_in_w;
            assign carry_in_w = carry_bits(bits_i[c-1], HEIGHT_BELOW);
            assign bits_o[c]  = kept_w | (carry_in_w << KEPT);
        end
    end

endmodule

// File: rtl/popc_pipe_reg.sv
module popc_pipe_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= valid_i;
    end

    // Data is captured only with a valid word and is never reset.
    always_ff @(posedge clk) begin
        if (valid_i) data_o <= data_i;
    end

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_o == $past(valid_i)));

    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid_o);

endmodule

// File: rtl/popc_class.sv
module popc_class
    import popc_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [CW-1:0] count_i,
    output logic [2:0]    class_o
);

    always_comb begin
        if (count_i > CW'(3)) class_o = CLASS_MANY;
        else                  class_o = {1'b0, count_i[1:0]};
    end

endmodule

// File: rtl/popc_csa_tree.sv
module popc_csa_tree
    import popc_pkg::*;
#(
    parameter int  WIDTH          = 32,
    parameter int  STAGES_PER_REG = 2,
    localparam int CNT_W          = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count,
    output logic [2:0]       out_class
);

    localparam int NCOL   = CNT_W;
    localparam int NSTAGE = tree_depth(WIDTH, NCOL);

    typedef logic [NCOL-1:0][WIDTH-1:0] level_t;

    level_t lvl_d [NSTAGE+1];
    logic   lvl_v [NSTAGE+1];
    level_t stg_o [NSTAGE+1];

    function automatic int level_weight(input level_t v);
        int w;
        w = 0;
        for (int c = 0; c < NCOL; c++) w = w + ($countones(v[c]) << c);
        return w;
    endfunction

    assign lvl_d[0] = level_t'(in_data);
    assign lvl_v[0] = in_valid;
    assign stg_o[0] = lvl_d[0];

    for (genvar s = 1; s <= NSTAGE; s++) begin : g_stage
        popc_stage #(
            .WIDTH (WIDTH),
            .NCOL  (NCOL),
            .STAGE (s - 1)
        ) u_stage (
            .bits_i (lvl_d[s-1]),
            .bits_o (stg_o[s])
        );

        if (STAGES_PER_REG > 0 && (s % STAGES_PER_REG) == 0) begin : g_reg
            popc_pipe_reg #(
                .DW (NCOL * WIDTH)
            ) u_reg (
                .clk     (clk),
                .rst     (rst),
                .valid_i (lvl_v[s-1]),
                .data_i  (stg_o[s]),
                .valid_o (lvl_v[s]),
                .data_o  (lvl_d[s])
            );
        end else begin : g_wire
            assign lvl_d[s] = stg_o[s];
            assign lvl_v[s] = lvl_v[s-1];
        end

        assert_stage_weight_R2: assert property (@(posedge clk) disable iff (rst)
            lvl_v[s-1] |-> (level_weight(stg_o[s]) == level_weight(lvl_d[s-1])));
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_out
        assign out_count[c] = lvl_d[NSTAGE][c][0];
    end

    assign out_valid = lvl_v[NSTAGE];

    popc_class #(
        .CW (CNT_W)
    ) u_class (
        .count_i (out_count),
        .class_o (out_class)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_chk_col
        assert_single_bit_column_R4: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (lvl_d[NSTAGE][c][WIDTH-1:1] == '0));
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_count) <= WIDTH));

    assert_class_many_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == CLASS_MANY) |-> (int'(out_count) > 3));

    assert_class_exact_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class < CLASS_MANY) |-> (int'(out_count) == int'(out_class)));

endmodule

// File: tb/popc_csa_tree_bench.sv
module popc_csa_tree_bench;

    localparam int N   = 32;
    localparam int CW  = $clog2(N + 1);
    localparam int LAT = 4;
    localparam int NC  = 7;
    localparam int CCW = $clog2(NC + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [N-1:0]  in_data;
    logic          out_valid;
    logic [CW-1:0] out_count;
    logic [2:0]    out_class;

    logic           c_valid;
    logic [NC-1:0]  c_data;
    logic           c_out_valid;
    logic [CCW-1:0] c_count;
    logic [2:0]     c_class;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    popc_csa_tree #(.WIDTH(N), .STAGES_PER_REG(2)) u_popc_csa_tree (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_count (out_count),
        .out_class (out_class)
    );

    popc_csa_tree #(.WIDTH(NC), .STAGES_PER_REG(0)) u_popc_csa_tree_comb (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (c_valid),
        .in_data   (c_data),
        .out_valid (c_out_valid),
        .out_count (c_count),
        .out_class (c_class)
    );

    // Expected-value history: word accepted at each edge, flushed by reset.
    logic         hv [LAT];
    logic [N-1:0] hd [LAT];

    always @(posedge clk) begin
        for (int i = LAT - 1; i > 0; i--) begin
            hv[i] <= rst ? 1'b0 : hv[i-1];
            hd[i] <= hd[i-1];
        end
        hv[0] <= rst ? 1'b0 : in_valid;
        hd[0] <= in_data;
    end

    function automatic int ones_in(input logic [63:0] v, input int w);
        int n;
        n = 0;
        for (int i = 0; i < w; i++) if (v[i]) n++;
        return n;
    endfunction

    function automatic int class_of(input int n);
        return (n > 3) ? 4 : n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_cycle();
        int n;
        check("R6 R5 out_valid alignment", int'(out_valid), int'(hv[LAT-1]));
        if (hv[LAT-1]) begin
            n = ones_in(64'(hd[LAT-1]), N);
            check("R1 count", int'(out_count), n);
            check("R8 class", int'(out_class), class_of(n));
        end
    endtask

    task automatic push(input logic v, input logic [N-1:0] d);
        @(negedge clk);
        check_cycle();
        in_valid = v;
        in_data  = d;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        void'($urandom(32'h5EED_0042));
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        c_valid  = 1'b0;
        c_data   = '0;
        repeat (3) @(negedge clk);
        check("R7 out_valid low in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 out_valid low after reset", int'(out_valid), 0);

        // R3 extremes
        push(1'b1, '0);
        push(1'b1, '1);
        // single set bits at several positions
        for (int i = 0; i < N; i += 5) push(1'b1, N'(1) << i);
        push(1'b1, N'(1) << (N - 1));
        // class boundaries R8: 2, 3, 4, 5 set bits
        push(1'b1, N'(32'h0000_0011));
        push(1'b1, N'(32'h8000_0101));
        push(1'b1, N'(32'h8010_0101));
        push(1'b1, N'(32'hC010_0101));
        push(1'b1, N'(32'h5555_5555));
        push(1'b1, N'(32'hFFFF_FFFE));
        // isolated word between bubbles: R5 latency of 4 cycles
        push(1'b0, N'(32'hDEAD_BEEF));
        push(1'b0, '0);
        push(1'b1, N'(32'h0F0F_00FF));
        for (int i = 0; i < LAT + 2; i++) push(1'b0, N'($urandom));

        // random traffic, dense and sparse, with bubbles
        for (int i = 0; i < 400; i++) begin
            r = N'($urandom);
            if (i % 3 == 1) r = r & N'($urandom) & N'($urandom) & N'($urandom);
            push(($urandom % 4) != 0, r);
        end

        // R7: reset with words in flight
        push(1'b1, '1);
        push(1'b1, N'(32'h1234_5678));
        @(negedge clk);
        check_cycle();
        rst      = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            check("R7 no valid after reset", int'(out_valid), 0);
        end
        push(1'b1, N'(32'h0000_0007));
        for (int i = 0; i < LAT + 1; i++) push(1'b0, '0);

        // K = 0 instance, 7-bit word: exhaustive, same-cycle result
        for (int v = 0; v < 128; v++) begin
            c_valid = v[0];
            c_data  = NC'(v);
            #1;
            check("R5 comb valid", int'(c_out_valid), v % 2);
            check("R1 R3 comb count", int'(c_count), ones_in(64'(v), NC));
            check("R8 comb class", int'(c_class), class_of(ones_in(64'(v), NC)));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule